// File: doc/BRIEF.md
# Serial Memory Target with Two-Wire Slave Front End

This block is a two-wire bus slave that looks like a small byte-wide serial memory. A fast system clock samples the bus clock and data lines. The block spots start and stop conditions on the bus and accepts an address byte. It then acknowledges the bytes it receives, writes data into an internal array and streams bytes back on reads. The data line is open-drain. The block never drives it high; it only asserts an output enable that pulls the line low.

The address byte has a fixed four-bit device code of `1010`. Three select bits follow, and these must equal the strap pins. The last bit picks the direction. A write frame carries one word-address byte that loads the internal pointer, followed by any number of data bytes. A read frame returns bytes from the pointer for as long as the master acknowledges them. A random read is a write frame that carries only the word address, then a repeated start and a read frame. A current-address read is a read frame on its own.

Top module: `serial_mem_target`

## Requirements
- R1: After reset, and whenever no start condition has been seen, clocked bus traffic draws no response: `sda_oe` stays 0. A start is SDA falling while SCL is high.
- R2: An address byte whose upper four bits are `1010` and whose next three bits equal `strap[2:0]` (MSB first) is acknowledged: SDA is held low through the ninth SCL pulse.
- R3: An address byte that fails the match is not acknowledged. The block then ignores all traffic until the next start or stop, and the memory keeps its contents.
- R4: In a write frame (address LSB 0), the first byte after the address loads the pointer. Each later byte is stored at the pointer. Every one of these bytes is acknowledged.
- R5: The pointer advances by one after each byte written or read, and wraps from 255 to 0.
- R6: Read data leaves MSB first. `sda_oe` changes only while SCL is low.
- R7: After a read byte, a master ACK (SDA low on the ninth pulse) makes the next byte follow. A NACK makes the block release SDA and ignore traffic until a stop or a start.
- R8: A write frame that holds only a word address, followed by a repeated start and a read frame, returns the byte at that word address.
- R9: A read frame with no word-address phase returns the byte at the pointer left by the previous operation.
- R10: A stop (SDA rising while SCL is high) ends the command. The block returns to idle with SDA released, and it does not answer bytes that arrive before the next start.
- R11: A start seen at any bit position, including in the middle of a byte, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| strap | input | 3 | Device select straps compared with the address byte |

## Verification
Two events can meet in one bus period. A start can arrive at the same point where the byte receiver is mid-shift, and the pointer update can coincide with the last byte of a sequential read before a wrap. The bench cuts an address byte after four bits with a repeated start and judges the case by whether the fresh address gets its acknowledge. It also writes across the 255-to-0 boundary and reads back through the wrap in a single acknowledged burst, comparing each byte against the values it wrote.

// File: rtl/sm_tgt_pkg.sv
package sm_tgt_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_DEVSEL = 3'd1,
      PH_WORD   = 3'd2,
      PH_WRITE  = 3'd3,
      PH_READ   = 3'd4,
      PH_IGNORE = 3'd5
   } phase_t;

   localparam logic [3:0] BIT_LAST = 4'd8;
   localparam logic [3:0] ACK_DONE = 4'd9;

endpackage

// File: rtl/sm_line_sync.sv
module sm_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("sm_line_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/sm_bus_events.sv
module sm_bus_events #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_s;
   logic scl_q;
   logic sda_q;

   sm_line_sync #(.STAGES(STAGES)) u_scl_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (scl_in),
      .dout (scl_s)
   );

   sm_line_sync #(.STAGES(STAGES)) u_sda_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sda_in),
      .dout (sda_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/sm_byte_store.sv
module sm_byte_store #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/sm_frame_ctrl.sv
module sm_frame_ctrl
   import sm_tgt_pkg::*;
#(
   parameter int               AW       = 8,
   parameter int               CODE_W   = 4,
   parameter int               SEL_W    = 3,
   parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [SEL_W-1:0] strap,
   input  logic [7:0]       rd_data,
   output logic             sda_oe,
   output logic [AW-1:0]    ptr,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [7:0]       wr_data,
   output phase_t           state
);

   localparam int BYTE_W = CODE_W + SEL_W + 1;

   generate
      if (BYTE_W != 8) begin : g_bad_fmt
         $error("sm_frame_ctrl: code, select and direction must fill one byte");
      end
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("sm_frame_ctrl: AW must lie in 1..8");
      end
   endgenerate

   logic [7:0] shreg;
   logic [7:0] tx;
   logic [3:0] cnt;
   logic       rw;
   logic       mack;
   logic       addr_hit;

   assign addr_hit = (shreg[7 -: CODE_W] == DEV_CODE) && (shreg[SEL_W:1] == strap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PH_IDLE;
         cnt     <= 4'd0;
         shreg   <= 8'd0;
         tx      <= 8'd0;
         ptr     <= '0;
         sda_oe  <= 1'b0;
         rw      <= 1'b0;
         mack    <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= 8'd0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state  <= PH_DEVSEL;
            cnt    <= 4'd0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= PH_IDLE;
            cnt    <= 4'd0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               PH_DEVSEL, PH_WORD, PH_WRITE: begin
                  if (scl_rise && cnt < BIT_LAST) begin
                     shreg <= {shreg[6:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == BIT_LAST) begin
                     if (state == PH_DEVSEL) begin
                        if (addr_hit) begin
                           sda_oe <= 1'b1;
                           rw     <= shreg[0];
                           cnt    <= ACK_DONE;
                        end else begin
                           state <= PH_IGNORE;
                           cnt   <= 4'd0;
                        end
                     end else if (state == PH_WORD) begin
                        ptr    <= shreg[AW-1:0];
                        sda_oe <= 1'b1;
                        cnt    <= ACK_DONE;
                     end else begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= shreg;
                        ptr     <= ptr + 1'b1;
                        sda_oe  <= 1'b1;
                        cnt     <= ACK_DONE;
                     end
                  end else if (scl_fall && cnt == ACK_DONE) begin
                     sda_oe <= 1'b0;
                     cnt    <= 4'd0;
                     if (state == PH_DEVSEL) begin
                        if (rw) begin
                           state  <= PH_READ;
                           tx     <= rd_data;
                           sda_oe <= ~rd_data[7];
                           ptr    <= ptr + 1'b1;
                        end else begin
                           state <= PH_WORD;
                        end
                     end else if (state == PH_WORD) begin
                        state <= PH_WRITE;
                     end
                  end
               end
               PH_READ: begin
                  if (scl_rise) begin
                     if (cnt < BIT_LAST) begin
                        cnt <= cnt + 4'd1;
                     end else if (cnt == BIT_LAST) begin
                        mack <= ~sda_s;
                        cnt  <= ACK_DONE;
                     end
                  end else if (scl_fall) begin
                     if (cnt < BIT_LAST) begin
                        sda_oe <= ~tx[3'd7 - cnt[2:0]];
                     end else if (cnt == BIT_LAST) begin
                        sda_oe <= 1'b0;
                     end else begin
                        cnt <= 4'd0;
                        if (mack) begin
                           tx     <= rd_data;
                           sda_oe <= ~rd_data[7];
                           ptr    <= ptr + 1'b1;
                        end else begin
                           state  <= PH_IGNORE;
                           sda_oe <= 1'b0;
                        end
                     end
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
   import sm_tgt_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                AW          = 8,
   parameter int                CODE_W      = 4,
   parameter int                SEL_W       = 3,
   parameter logic [CODE_W-1:0] DEV_CODE    = 4'b1010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic [SEL_W-1:0] strap
);

   localparam int DW = 8;

   logic          sda_s;
   logic          scl_rise;
   logic          scl_fall;
   logic          start_det;
   logic          stop_det;
   logic [AW-1:0] ptr;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] rd_data;
   phase_t        state;

   sm_bus_events #(.STAGES(SYNC_STAGES)) u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (scl_i),
      .sda_in   (sda_i),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   sm_frame_ctrl #(
      .AW      (AW),
      .CODE_W  (CODE_W),
      .SEL_W   (SEL_W),
      .DEV_CODE(DEV_CODE)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .strap    (strap),
      .rd_data  (rd_data),
      .sda_oe   (sda_oe),
      .ptr      (ptr),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .state    (state)
   );

   sm_byte_store #(.AW(AW), .DW(DW)) u_store (
      .clk  (clk),
      .we   (wr_en),
      .waddr(wr_addr),
      .wdata(wr_data),
      .raddr(ptr),
      .rdata(rd_data)
   );

endmodule

// File: rtl/serial_mem_target_chk.sv
module serial_mem_target_chk
   import sm_tgt_pkg::*;
#(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_i,
   input logic          sda_oe,
   input logic          start_det,
   input logic          stop_det,
   input logic [AW-1:0] ptr,
   input phase_t        state
);

   // R1: with no command open the pad is never pulled
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_IDLE) |-> !sda_oe);

   // R6: the data line only moves while the bus clock is low
   assert_oe_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   // R3 / R7: once ignoring, the line stays released
   assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_IGNORE && $past(state) == PH_IGNORE) |-> !sda_oe);

   // R5: during a read burst the pointer moves by exactly one (wrap included)
   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_READ && $past(state) == PH_READ && ptr != $past(ptr))
      |-> ptr == $past(ptr) + 1'b1);

   // R10: a stop returns to idle with the line released
   assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == PH_IDLE && !sda_oe));

   // R11: a start always reopens address reception
   assert_start_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == PH_DEVSEL && !sda_oe));

endmodule

bind serial_mem_target serial_mem_target_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_i    (scl_i),
   .sda_oe   (sda_oe),
   .start_det(start_det),
   .stop_det (stop_det),
   .ptr      (ptr),
   .state    (state)
);

// File: tb/serial_mem_target_test.sv
`timescale 1ns/1ps
module serial_mem_target_test;

   localparam int         Q   = 8;
   localparam logic [2:0] SEL = 3'b101;
   localparam logic [7:0] WR  = {4'b1010, SEL, 1'b0};
   localparam logic [7:0] RD  = {4'b1010, SEL, 1'b1};
   localparam int         NV  = 8;
   // each entry: {word address, data}; expected read-back equals data
   localparam logic [15:0] VEC [NV] = '{16'h013C, 16'h10A5, 16'h055A, 16'h80FE,
                                        16'h7F01, 16'h2000, 16'h33C3, 16'hFE81};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic [2:0] strap = SEL;
   logic sda_oe;
   logic sda_line;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   assign sda_line = m_sda & ~sda_oe;

   always #4 clk = ~clk;

   serial_mem_target uut (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (m_scl),
      .sda_i (sda_line),
      .sda_oe(sda_oe),
      .strap (strap)
   );

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; qw();
      m_scl = 1'b1; qw();
      m_sda = 1'b0; qw();
      m_scl = 1'b0; qw();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; qw();
      m_scl = 1'b1; qw();
      m_sda = 1'b1; qw();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; qw();
         m_scl = 1'b1; qw(); qw();
         m_scl = 1'b0; qw();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      m_sda = 1'b1; qw();
      m_scl = 1'b1; qw();
      ack = ~sda_line;
      qw();
      m_scl = 1'b0; qw();
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit give_ack);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         qw();
         m_scl = 1'b1; qw();
         b[i] = sda_line;
         qw();
         m_scl = 1'b0;
      end
      qw();
      m_sda = give_ack ? 1'b0 : 1'b1; qw();
      m_scl = 1'b1; qw(); qw();
      m_scl = 1'b0; qw();
      m_sda = 1'b1;
   endtask

   task automatic wr_one(input logic [7:0] a, input logic [7:0] d);
      bit a1, a2, a3;
      bus_start();
      send_byte(WR, a1);
      send_byte(a, a2);
      send_byte(d, a3);
      bus_stop();
      chk(a1, "R2 address ack on write", {7'd0, a1}, 8'h01);
      chk(a2 && a3, "R4 word/data ack", {6'd0, a2, a3}, 8'h03);
   endtask

   task automatic rd_rand(input logic [7:0] a, output logic [7:0] d);
      bit a1, a2, a3;
      bus_start();
      send_byte(WR, a1);
      send_byte(a, a2);
      bus_start();
      send_byte(RD, a3);
      recv_byte(d, 1'b0);
      bus_stop();
      chk(a1 && a2 && a3, "R8 random read acks", {5'd0, a1, a2, a3}, 8'h07);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      bit         ack;
      bit         ack2;
      logic [7:0] d;
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 reset state", {7'd0, sda_oe}, 8'h00);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: a full address byte with no start
      send_byte(WR, ack);
      chk(!ack, "R1 no start no ack", {7'd0, ack}, 8'h00);
      bus_stop();

      // table walk: writes then random reads (R2, R4, R8)
      for (int k = 0; k < NV; k++) wr_one(VEC[k][15:8], VEC[k][7:0]);
      for (int k = 0; k < NV; k++) begin
         rd_rand(VEC[k][15:8], d);
         chk(d == VEC[k][7:0], "R8 random read data", d, VEC[k][7:0]);
      end

      // R5: writes across the top of the array wrap to 0
      bus_start();
      send_byte(WR, ack);
      send_byte(8'hFF, ack);
      send_byte(8'h11, ack);
      send_byte(8'h22, ack2);
      bus_stop();
      chk(ack && ack2, "R4 burst write ack", {6'd0, ack, ack2}, 8'h03);

      // R5/R7: sequential read across the wrap, ended by NACK
      bus_start();
      send_byte(WR, ack);
      send_byte(8'hFF, ack);
      bus_start();
      send_byte(RD, ack);
      recv_byte(d, 1'b1);
      chk(d == 8'h11, "R5 read at 255", d, 8'h11);
      recv_byte(d, 1'b1);
      chk(d == 8'h22, "R5 wrapped read at 0", d, 8'h22);
      recv_byte(d, 1'b0);
      chk(d == 8'h3C, "R7 ack continues to 1", d, 8'h3C);
      chk(sda_oe == 1'b0, "R7 released after nack", {7'd0, sda_oe}, 8'h00);
      recv_byte(d, 1'b1);
      chk(d == 8'hFF, "R7 silent after nack", d, 8'hFF);
      bus_stop();

      // R3: wrong device code, then wrong straps; nothing answered or stored
      bus_start();
      send_byte({4'b1011, SEL, 1'b0}, ack);
      chk(!ack, "R3 wrong code no ack", {7'd0, ack}, 8'h00);
      send_byte(8'h05, ack);
      send_byte(8'h77, ack2);
      chk(!ack && !ack2, "R3 later bytes ignored", {6'd0, ack, ack2}, 8'h00);
      bus_stop();
      bus_start();
      send_byte({4'b1010, 3'b010, 1'b0}, ack);
      chk(!ack, "R3 wrong strap no ack", {7'd0, ack}, 8'h00);
      send_byte(8'h05, ack);
      send_byte(8'h77, ack2);
      bus_stop();
      rd_rand(8'h05, d);
      chk(d == 8'h5A, "R3 memory untouched", d, 8'h5A);

      // R10: stop after the word address, then a stray byte
      bus_start();
      send_byte(WR, ack);
      send_byte(8'h10, ack);
      bus_stop();
      chk(sda_oe == 1'b0, "R10 released after stop", {7'd0, sda_oe}, 8'h00);
      send_byte(WR, ack);
      chk(!ack, "R10 no answer after stop", {7'd0, ack}, 8'h00);
      bus_stop();

      // R9: current-address read uses pointer 0x10
      bus_start();
      send_byte(RD, ack);
      chk(ack, "R2 address ack on read", {7'd0, ack}, 8'h01);
      recv_byte(d, 1'b0);
      bus_stop();
      chk(d == 8'hA5, "R9 current address read", d, 8'hA5);

      // R11: start in the middle of an address byte
      bus_start();
      send_bits(WR, 4);
      bus_start();
      send_byte(WR, ack);
      chk(ack, "R11 restart mid byte acked", {7'd0, ack}, 8'h01);
      send_byte(8'h33, ack);
      bus_start();
      send_byte(RD, ack);
      recv_byte(d, 1'b0);
      bus_stop();
      chk(d == 8'hC3, "R11 read after restart", d, 8'hC3);

      // R6: first read bit is the MSB (0x80 -> 0xFE, MSB 1; 0x7F -> 0x01, MSB 0)
      rd_rand(8'h7F, d);
      chk(d[7] == 1'b0 && d[0] == 1'b1, "R6 msb first", d, 8'h01);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule